// File: doc/BRIEF.md
# Serial Configuration Register Loader

This block holds the configuration of a clock generator and is loaded through a three-wire serial port. A host pulls an active-low frame strobe low and toggles a serial clock. On each rising serial-clock edge the block captures one data bit. A full frame is a 15-bit word sent least significant bit first. The word holds an 11-bit payload in bits 0 to 10, a register address in bits 11 to 13 and a direction flag in bit 14. A flag of 0 means write and 1 means read. When the strobe is released after exactly 15 bits, a write frame stores its payload in the addressed register. A read frame instead loads the addressed register into a readback shifter.

The serial inputs are brought into the system clock domain through two-stage synchronisers, and all edges are detected there. Seven 11-bit registers come out of reset with fixed defaults. Every field in those registers drives its own parallel output, so downstream divider, phase-detector and output-mux logic can use the fields directly. Reserved bits always hold one.

After a read frame, the next frame shifts the stored value out on the serial data output, least significant bit first. Each rising serial-clock edge of that frame advances the output by one bit.

Top module: `clkgen_cfg_loader`

## Requirements
- R1: After reset the registers hold 0x04F, 0x003, 0x006, 0x013, 0x5DC, 0x5C1 and 0x087 for addresses 0 to 6. Each parallel field output reflects these values.
- R2: A frame whose strobe rises after exactly 15 rising serial-clock edges is taken as a word with bit 0 first: payload in bits 0 to 10, address in bits 11 to 13, flag in bit 14.
- R3: A write frame (flag 0) to address 0 to 6 replaces that register with the payload and leaves all other registers unchanged.
- R4: Bit 10 of address 4 and bit 10 of address 5 are reserved and always read as one, whatever is written to them.
- R5: A write frame to address 7 changes no register.
- R6: A frame with any bit count other than 15 changes no register.
- R7: A read frame (flag 1) changes no register.
- R8: After a read frame, the next frame presents the addressed register on the serial output. Bit 0 appears before that frame's first rising serial-clock edge, and each rising edge advances to the next bit. Address 7 reads as zero.
- R9: Address 6 drives a 3-bit post-scaler from bits 0 to 2 and four output selects from bits 3 to 6 (bit 3 is select 0). Bits 7 to 10 drive the output-reset, test-enable, test-clock and reference-select flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, data captured on rising edge |
| ser_din | input | 1 | Serial data in |
| frame_n | input | 1 | Active-low frame strobe |
| ser_dout | output | 1 | Serial readback data |
| fb_mod | output | 11 | Address 0 bits 0-10: feedback divider value |
| sync_lo | output | 8 | Address 1 bits 0-7: low sync state |
| sync_hi | output | 8 | Address 2 bits 0-7: high sync state |
| ref_mod | output | 10 | Address 3 bits 0-9: reference divider value |
| ref_inv | output | 1 | Address 3 bit 10: reference polarity invert |
| vco_gain | output | 3 | Address 4 bits 0-2 |
| pd_gain | output | 3 | Address 4 bits 3-5 |
| pd_en | output | 1 | Address 4 bit 6 |
| loop_int | output | 1 | Address 4 bit 7: internal loop filter |
| vco_int | output | 1 | Address 4 bit 8: internal oscillator |
| fb_clk_sel | output | 1 | Address 4 bit 9 |
| fb_sel | output | 1 | Address 5 bit 0 |
| fb_inv | output | 1 | Address 5 bit 1 |
| cyc_add | output | 1 | Address 5 bit 2 |
| cyc_swallow | output | 1 | Address 5 bit 3 |
| out_scale | output | 2 | Address 5 bits 4-5 |
| fb_scale | output | 2 | Address 5 bits 6-7 |
| phase_lead | output | 1 | Address 5 bit 8 |
| phase_en | output | 1 | Address 5 bit 9 |
| post_div | output | 3 | Address 6 bits 0-2 |
| out_sel | output | 4 | Address 6 bits 3-6 |
| out_reset | output | 1 | Address 6 bit 7 |
| test_en | output | 1 | Address 6 bit 8 |
| test_clk | output | 1 | Address 6 bit 9 |
| ext_ref_sel | output | 1 | Address 6 bit 10 |

## Verification
The hardest case to reach is a readback that spans two frames. The loaded value has to survive the strobe going low again, and each bit has to be observed just before the serial edge that moves it on. The bench reaches this by following every random read frame with a short 11-bit frame of random data, and it compares the serial output bit by bit with its own model. That follow-up frame is also a wrong-length frame, so every readback also shows that a miscounted frame leaves the registers alone. Random bit counts of 14, 15 and 16 and random addresses including 7 cover the remaining discard paths.

// File: rtl/clkgen_cfg_loader.sv
module clkgen_cfg_loader #(
  parameter int DATA_W = 11,
  parameter int ADDR_W = 3,
  parameter int NREG   = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_clk,
  input  logic       ser_din,
  input  logic       frame_n,
  output logic       ser_dout,
  output logic [10:0] fb_mod,
  output logic [7:0] sync_lo,
  output logic [7:0] sync_hi,
  output logic [9:0] ref_mod,
  output logic       ref_inv,
  output logic [2:0] vco_gain,
  output logic [2:0] pd_gain,
  output logic       pd_en,
  output logic       loop_int,
  output logic       vco_int,
  output logic       fb_clk_sel,
  output logic       fb_sel,
  output logic       fb_inv,
  output logic       cyc_add,
  output logic       cyc_swallow,
  output logic [1:0] out_scale,
  output logic [1:0] fb_scale,
  output logic       phase_lead,
  output logic       phase_en,
  output logic [2:0] post_div,
  output logic [3:0] out_sel,
  output logic       out_reset,
  output logic       test_en,
  output logic       test_clk,
  output logic       ext_ref_sel
);
  localparam int WORD_W = DATA_W + ADDR_W + 1;
  localparam int CNT_W  = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

  function automatic logic [DATA_W-1:0] dflt(int i);
    case (i)
      0: return DATA_W'(11'h04F);
      1: return DATA_W'(11'h003);
      2: return DATA_W'(11'h006);
      3: return DATA_W'(11'h013);
      4: return DATA_W'(11'h5DC);
      5: return DATA_W'(11'h5C1);
      6: return DATA_W'(11'h087);
      default: return '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] rsv(int i);
    case (i)
      4, 5: return DATA_W'(11'h400);
      default: return '0;
    endcase
  endfunction

  logic [2:0] sck_q, frm_q;
  logic [1:0] din_q;
  logic sck_rise, frm_low, frm_end;
  logic [WORD_W-1:0] word;
  logic [CNT_W-1:0] bit_cnt;
  logic [DATA_W-1:0] rd_sh, rd_word;
  logic [DATA_W-1:0] cfg [NREG];
  logic [NREG*DATA_W-1:0] cfg_flat;
  logic [ADDR_W-1:0] w_addr;
  logic w_rd, w_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      frm_q <= '1;
      din_q <= '0;
    end else begin
      sck_q <= {sck_q[1:0], ser_clk};
      frm_q <= {frm_q[1:0], frame_n};
      din_q <= {din_q[0], ser_din};
    end
  end

  assign sck_rise = sck_q[1] & ~sck_q[2];
  assign frm_low  = ~frm_q[1];
  assign frm_end  = frm_q[1] & ~frm_q[2];
  assign w_addr   = word[DATA_W +: ADDR_W];
  assign w_rd     = word[WORD_W-1];
  assign w_ok     = frm_end && bit_cnt == CNT_FULL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word    <= '0;
      bit_cnt <= '0;
    end else if (!frm_low) begin
      bit_cnt <= '0;
    end else if (sck_rise) begin
      word <= {din_q[1], word[WORD_W-1:1]};
      if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NREG; i++)
      if (w_addr == ADDR_W'(i)) rd_word = cfg[i];
  end

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg[g] <= dflt(g);
        else if (w_ok && !w_rd && w_addr == ADDR_W'(g))
          cfg[g] <= word[DATA_W-1:0] | rsv(g);
      end
      assign cfg_flat[g*DATA_W +: DATA_W] = cfg[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_sh <= '0;
    else if (w_ok && w_rd) rd_sh <= rd_word;
    else if (frm_low && sck_rise) rd_sh <= {1'b0, rd_sh[DATA_W-1:1]};
  end

  assign ser_dout = rd_sh[0];

  assign fb_mod      = cfg[0][10:0];
  assign sync_lo     = cfg[1][7:0];
  assign sync_hi     = cfg[2][7:0];
  assign ref_mod     = cfg[3][9:0];
  assign ref_inv     = cfg[3][10];
  assign vco_gain    = cfg[4][2:0];
  assign pd_gain     = cfg[4][5:3];
  assign pd_en       = cfg[4][6];
  assign loop_int    = cfg[4][7];
  assign vco_int     = cfg[4][8];
  assign fb_clk_sel  = cfg[4][9];
  assign fb_sel      = cfg[5][0];
  assign fb_inv      = cfg[5][1];
  assign cyc_add     = cfg[5][2];
  assign cyc_swallow = cfg[5][3];
  assign out_scale   = cfg[5][5:4];
  assign fb_scale    = cfg[5][7:6];
  assign phase_lead  = cfg[5][8];
  assign phase_en    = cfg[5][9];
  assign post_div    = cfg[6][2:0];
  assign out_sel     = cfg[6][6:3];
  assign out_reset   = cfg[6][7];
  assign test_en     = cfg[6][8];
  assign test_clk    = cfg[6][9];
  assign ext_ref_sel = cfg[6][10];

  p_cfg_only_at_frame_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_end |=> $stable(cfg_flat));
  p_reserved_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg[4][10] && cfg[5][10]);
  p_addr7_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frm_end && w_addr >= ADDR_W'(NREG) |=> $stable(cfg_flat));
  p_bad_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frm_end && bit_cnt != CNT_FULL |=> $stable(cfg_flat));
  p_read_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frm_end && w_rd |=> $stable(cfg_flat));
  p_rd_shift_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_end && !sck_rise |=> $stable(rd_sh));
endmodule

// File: tb/clkgen_cfg_loader_tb_top.sv
module clkgen_cfg_loader_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_din = 1'b0, frame_n = 1'b1;
  logic ser_dout;
  logic [10:0] fb_mod;
  logic [7:0] sync_lo, sync_hi;
  logic [9:0] ref_mod;
  logic ref_inv, pd_en, loop_int, vco_int, fb_clk_sel, fb_sel, fb_inv;
  logic cyc_add, cyc_swallow, phase_lead, phase_en, out_reset, test_en, test_clk, ext_ref_sel;
  logic [2:0] vco_gain, pd_gain, post_div;
  logic [1:0] out_scale, fb_scale;
  logic [3:0] out_sel;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [10:0] m [7];

  always #2 clk = ~clk;

  clkgen_cfg_loader dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din), .frame_n(frame_n),
    .ser_dout(ser_dout), .fb_mod(fb_mod), .sync_lo(sync_lo), .sync_hi(sync_hi),
    .ref_mod(ref_mod), .ref_inv(ref_inv), .vco_gain(vco_gain), .pd_gain(pd_gain),
    .pd_en(pd_en), .loop_int(loop_int), .vco_int(vco_int), .fb_clk_sel(fb_clk_sel),
    .fb_sel(fb_sel), .fb_inv(fb_inv), .cyc_add(cyc_add), .cyc_swallow(cyc_swallow),
    .out_scale(out_scale), .fb_scale(fb_scale), .phase_lead(phase_lead),
    .phase_en(phase_en), .post_div(post_div), .out_sel(out_sel), .out_reset(out_reset),
    .test_en(test_en), .test_clk(test_clk), .ext_ref_sel(ext_ref_sel));

  function automatic logic [69:0] exp_fields();
    return {m[0], m[1][7:0], m[2][7:0], m[3][9:0], m[3][10], m[4][2:0], m[4][5:3],
            m[4][6], m[4][7], m[4][8], m[4][9], m[5][0], m[5][1], m[5][2], m[5][3],
            m[5][5:4], m[5][7:6], m[5][8], m[5][9], m[6][2:0], m[6][6:3], m[6][7],
            m[6][8], m[6][9], m[6][10]};
  endfunction

  function automatic logic [69:0] got_fields();
    return {fb_mod, sync_lo, sync_hi, ref_mod, ref_inv, vco_gain, pd_gain, pd_en,
            loop_int, vco_int, fb_clk_sel, fb_sel, fb_inv, cyc_add, cyc_swallow,
            out_scale, fb_scale, phase_lead, phase_en, post_div, out_sel, out_reset,
            test_en, test_clk, ext_ref_sel};
  endfunction

  function automatic logic [10:0] rsv_mask(int a);
    return (a == 4 || a == 5) ? 11'h400 : 11'h000;
  endfunction

  task automatic chk(string req, logic [69:0] got, logic [69:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [14:0] w, int nbits);
    frame_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      ser_din = (i < 15) ? w[i] : 1'b1;
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
    end
    wait_clk(4);
    frame_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic model_apply(logic [14:0] w, int nbits);
    int a = int'(w[13:11]);
    if (nbits == 15 && !w[14] && a < 7) m[a] = w[10:0] | rsv_mask(a);
  endtask

  task automatic read_back(int a, string req);
    logic [10:0] got;
    logic [10:0] exp = (a < 7) ? m[a] : 11'h000;
    send({1'b1, 3'(a), 11'h2A5}, 15);
    frame_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < 11; i++) begin
      ser_din = 1'($urandom);
      wait_clk(3);
      got[i] = ser_dout;
      wait_clk(1);
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
    end
    wait_clk(4);
    frame_n = 1'b1;
    wait_clk(8);
    chk(req, 70'(got), 70'(exp));
    chk({req, " R6 R7 no change"}, got_fields(), exp_fields());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1522));
    m[0] = 11'h04F; m[1] = 11'h003; m[2] = 11'h006; m[3] = 11'h013;
    m[4] = 11'h5DC; m[5] = 11'h5C1; m[6] = 11'h087;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    // R1 reset defaults
    chk("R1 reset fields", got_fields(), exp_fields());
    for (int a = 0; a < 7; a++) read_back(a, "R1 R8 default readback");

    // R2 R3 directed write, R9 address 6 field split
    send({1'b0, 3'd6, 11'b101_1010_1101}, 15);
    model_apply({1'b0, 3'd6, 11'b101_1010_1101}, 15);
    chk("R9 post_div", 70'(post_div), 70'(3'b101));
    chk("R9 out_sel", 70'(out_sel), 70'(4'b0101));
    chk("R2 R3 fields", got_fields(), exp_fields());

    // R4 reserved forced to one
    send({1'b0, 3'd4, 11'h000}, 15); model_apply({1'b0, 3'd4, 11'h000}, 15);
    send({1'b0, 3'd5, 11'h000}, 15); model_apply({1'b0, 3'd5, 11'h000}, 15);
    read_back(4, "R4 reserved addr4");
    read_back(5, "R4 reserved addr5");

    // R5 address 7 write ignored
    send({1'b0, 3'd7, 11'h7FF}, 15);
    chk("R5 addr7 write", got_fields(), exp_fields());
    read_back(7, "R8 addr7 reads zero");

    // R6 wrong counts
    send({1'b0, 3'd0, 11'h123}, 14);
    chk("R6 short frame", got_fields(), exp_fields());
    send({1'b0, 3'd0, 11'h123}, 16);
    chk("R6 long frame", got_fields(), exp_fields());

    // R7 read frame leaves state
    send({1'b1, 3'd0, 11'h555}, 15);
    chk("R7 read no write", got_fields(), exp_fields());

    // random mix
    for (int it = 0; it < 80; it++) begin
      logic [14:0] w = 15'($urandom);
      int nb = (($urandom % 5) == 0) ? 14 + int'($urandom % 3) : 15;
      if (w[14]) begin
        read_back(int'(w[13:11]), "R8 random readback");
      end else begin
        send(w, nb);
        model_apply(w, nb);
        chk("R3 R5 R6 random write", got_fields(), exp_fields());
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule